// File: doc/BRIEF.md
# Atomic DMA Transfer Engine

This block carries out a single atomic DMA operation on a simple synchronous memory-bus master port. A channel sequencer hands it the current source and destination addresses, an element-size code, a unit-or-burst choice and, for each side, a flag that says whether that address advances or stays put. It then gives the block a one-cycle start pulse.

The engine first runs every read of the operation and keeps each returned word in a small internal buffer. It then runs every write and takes the data from that buffer in the same order the reads came back. When the last write is accepted, it raises a one-cycle done pulse and presents the updated source and destination addresses, ready for the next operation.

Counting whole transfers and arbitrating between channels are left to the surrounding logic.

Top module: `dma_atomic_xfer`

## Requirements
- R1: With `burst`=0, one operation is exactly one read of `src_addr` followed by one write to `dst_addr` that carries the word read.
- R2: With `burst`=1, one operation is four reads followed by four writes, with no read after any write. Write k carries the data of read k, for k = 0 to 3.
- R3: `size_code` 2'b00, 2'b01 and 2'b10 select 1-, 2- and 4-byte elements. `bus_size` shows the latched code during every access. An advancing address moves by 1, 2 or 4 after each accepted beat.
- R4: `src_inc`=1 makes the source address advance per element, and `src_inc`=0 holds it fixed. `dst_inc` does the same for the destination, independently of `src_inc`.
- R5: A start with `size_code`=2'b11 makes no bus access and gives no done pulse. It raises `err` for exactly the one cycle after the start.
- R6: A beat completes only in a cycle where `bus_req` and `bus_ready` are both high. While `bus_ready` is low, `bus_addr`, `bus_we` and `bus_wdata` hold their values.
- R7: `done` is high for exactly one cycle, the cycle after the last write is accepted. In that cycle `next_src` and `next_dst` equal the start addresses plus (elements × element bytes) for each advancing side, and equal the start addresses unchanged for each fixed side. `busy` is low from then on.
- R8: A start pulse received while `busy` is high is ignored. The running operation is not changed, and no further operation follows it.
- R9: After reset, `bus_req`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start pulse |
| src_addr | input | AW | Source address of the operation |
| dst_addr | input | AW | Destination address of the operation |
| size_code | input | 2 | Element size: 00 byte, 01 halfword, 10 word, 11 reserved |
| burst | input | 1 | 0 selects unit (one element), 1 selects burst (four elements) |
| src_inc | input | 1 | 1 advances the source address, 0 keeps it fixed |
| dst_inc | input | 1 | 1 advances the destination address, 0 keeps it fixed |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Element size code of the access |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid when `bus_ready` is high on a read |
| bus_ready | input | 1 | Beat accepted in this cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for the reserved size code |
| next_src | output | AW | Updated source address, valid with `done` |
| next_dst | output | AW | Updated destination address, valid with `done` |

## Verification
The main function is exercised across unit and burst modes, all three element sizes and all four combinations of fixed and advancing addresses. Together these separate a wrong step size, a swapped increment flag and a buffer that replays out of order. In the bench, memory returns a value derived from the address. Fixed and advancing sources therefore give different write data, and any reordering of burst beats shows up as a data mismatch.

Each pattern is run twice, once with the bus always ready and once with stalls. The stalled run tells a handshake-respecting engine apart from one that counts cycles instead of accepted beats.

The directed cases cover three further behaviours. The reserved size code must make no access and raise a single error pulse. A start pulse arriving during a busy operation must be ignored. After each operation, the done pulse must fall exactly one cycle after the final write.

// File: rtl/dma_atomic_xfer.sv
module dma_atomic_xfer #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [1:0]    size_code,
  input  logic          burst,
  input  logic          src_inc,
  input  logic          dst_inc,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] next_src,
  output logic [AW-1:0] next_dst
);
  localparam int IW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(BURST_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t        st;
  logic [AW-1:0] cur_src, cur_dst;
  logic [1:0]    size_q;
  logic          burst_q, sinc_q, dinc_q;
  logic [IW-1:0] idx;
  logic [DW-1:0] hold [BURST_LEN];
  logic          done_q, err_q;

  logic          beat, last_beat;
  logic [AW-1:0] step;

  assign step      = {{(AW-1){1'b0}}, 1'b1} << size_q;
  assign beat      = (st != S_IDLE) && bus_ready;
  assign last_beat = burst_q ? (idx == LAST_IDX) : 1'b1;

  assign bus_req   = (st != S_IDLE);
  assign bus_we    = (st == S_WRITE);
  assign bus_addr  = (st == S_WRITE) ? cur_dst : cur_src;
  assign bus_size  = size_q;
  assign bus_wdata = hold[idx];
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign next_src  = cur_src;
  assign next_dst  = cur_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_src <= '0;
      cur_dst <= '0;
      size_q  <= '0;
      burst_q <= 1'b0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      idx     <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (size_code == 2'b11) begin
              err_q <= 1'b1;
            end else begin
              st      <= S_READ;
              cur_src <= src_addr;
              cur_dst <= dst_addr;
              size_q  <= size_code;
              burst_q <= burst;
              sinc_q  <= src_inc;
              dinc_q  <= dst_inc;
              idx     <= '0;
            end
          end
        end
        S_READ: begin
          if (beat) begin
            if (sinc_q) cur_src <= cur_src + step;
            if (last_beat) begin
              idx <= '0;
              st  <= S_WRITE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_WRITE: begin
          if (beat) begin
            if (dinc_q) cur_dst <= cur_dst + step;
            if (last_beat) begin
              idx    <= '0;
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_READ && bus_ready) hold[idx] <= bus_rdata;
  end
endmodule

module dma_atomic_xfer_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    size_code,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          busy,
  input logic          done,
  input logic          err
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_req);
  a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  a_r5_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && size_code == 2'b11) |=> err && !bus_req);
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_size != 2'b11);
  a_r8_no_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !err);
endmodule

bind dma_atomic_xfer dma_atomic_xfer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_wdata(bus_wdata), .bus_ready(bus_ready), .busy(busy), .done(done), .err(err)
);

// File: tb/sim_dma_atomic_xfer.sv
`timescale 1ns/1ps
module sim_dma_atomic_xfer;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] src_addr = '0, dst_addr = '0;
  logic [1:0]  size_code = '0;
  logic        burst = 1'b0, src_inc = 1'b0, dst_inc = 1'b0;
  logic        bus_req, bus_we, bus_ready = 1'b1, busy, done, err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, next_src, next_dst;
  logic [1:0]  bus_size;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C5A_96E1;
  endfunction
  assign bus_rdata = mem_val(bus_addr);

  dma_atomic_xfer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
    .size_code(size_code), .burst(burst), .src_inc(src_inc), .dst_inc(dst_inc),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .done(done), .err(err), .next_src(next_src), .next_dst(next_dst)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, stall_mode = 0;
  int nr, nw, ndone, nerr, order_bad, size_bad, last_wr_cyc, done_cyc;
  logic [31:0] rd_a [8];
  logic [31:0] wr_a [8];
  logic [31:0] wr_d [8];
  logic [31:0] got_ns, got_nd;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    bus_ready = (stall_mode != 0) ? (cyc % 3 != 0) : 1'b1;
    if (bus_req && bus_ready) begin
      if (bus_size != size_code) size_bad++;
      if (!bus_we) begin
        if (nw != 0) order_bad++;
        if (nr < 8) rd_a[nr] = bus_addr;
        nr++;
      end else begin
        if (nw < 8) begin wr_a[nw] = bus_addr; wr_d[nw] = bus_wdata; end
        nw++;
        last_wr_cyc = cyc;
      end
    end
    if (done) begin ndone++; done_cyc = cyc; got_ns = next_src; got_nd = next_dst; end
    if (err) nerr++;
  end

  task automatic clear_log();
    nr = 0; nw = 0; ndone = 0; nerr = 0; order_bad = 0; size_bad = 0;
    last_wr_cyc = -10; done_cyc = -20;
  endtask

  task automatic launch(input logic [1:0] sz, input bit b, si, di, input logic [31:0] s, d);
    @(negedge clk); #1;
    clear_log();
    size_code = sz; burst = b; src_inc = si; dst_inc = di; src_addr = s; dst_addr = d;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 200; i++) begin
      if (ndone != 0 || nerr != 0) break;
      @(negedge clk); #1;
    end
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic verify(input logic [1:0] sz, input bit b, si, di, input logic [31:0] s, d);
    int n;
    logic [31:0] st;
    n = b ? 4 : 1;
    st = 32'd1 << sz;
    check(nr == n, b ? "R2 read count" : "R1 read count", nr, n);
    check(nw == n, b ? "R2 write count" : "R1 write count", nw, n);
    check(order_bad == 0, "R2 reads before writes", order_bad, 0);
    check(size_bad == 0, "R3 bus_size", size_bad, 0);
    for (int k = 0; k < n && k < 8; k++) begin
      check(rd_a[k] == s + (si ? k * st : 0), "R4 source address", rd_a[k], s + (si ? k * st : 0));
      check(wr_a[k] == d + (di ? k * st : 0), "R4 destination address", wr_a[k], d + (di ? k * st : 0));
      check(wr_d[k] == mem_val(s + (si ? k * st : 0)), "R2 write data order", wr_d[k], mem_val(s + (si ? k * st : 0)));
    end
    check(ndone == 1, "R7 done width", ndone, 1);
    check(done_cyc == last_wr_cyc + 1, "R7 done timing", done_cyc, last_wr_cyc + 1);
    check(got_ns == s + (si ? n * st : 0), "R3 next_src", got_ns, s + (si ? n * st : 0));
    check(got_nd == d + (di ? n * st : 0), "R3 next_dst", got_nd, d + (di ? n * st : 0));
    check(!busy, "R7 busy low", busy, 0);
  endtask

  localparam logic [68:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b1, 1'b1, 32'h0000_1000, 32'h0000_2000},
    {2'd1, 1'b0, 1'b1, 1'b0, 32'h0000_1102, 32'h0000_2202},
    {2'd2, 1'b0, 1'b0, 1'b1, 32'h0000_1204, 32'h0000_2304},
    {2'd0, 1'b1, 1'b1, 1'b1, 32'h0000_1301, 32'h0000_2401},
    {2'd1, 1'b1, 1'b1, 1'b0, 32'h0000_1402, 32'h0000_2502},
    {2'd2, 1'b1, 1'b0, 1'b1, 32'h0000_1500, 32'h0000_2600},
    {2'd2, 1'b1, 1'b1, 1'b1, 32'h0000_1608, 32'h0000_2708},
    {2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_1706, 32'h0000_2806}
  };

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    #1;
    check(!bus_req && !busy && !done && !err, "R9 reset outputs", {bus_req, busy, done, err}, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++) begin
      stall_mode = m;
      for (int v = 0; v < 8; v++) begin
        launch(VEC[v][68:67], VEC[v][66], VEC[v][65], VEC[v][64], VEC[v][63:32], VEC[v][31:0]);
        wait_end();
        verify(VEC[v][68:67], VEC[v][66], VEC[v][65], VEC[v][64], VEC[v][63:32], VEC[v][31:0]);
      end
    end

    stall_mode = 0;
    launch(2'b11, 1'b1, 1'b1, 1'b1, 32'h0000_3000, 32'h0000_4000);
    check(err, "R5 err after reserved start", err, 1);
    wait_end();
    check(nr + nw == 0, "R5 no bus access", nr + nw, 0);
    check(nerr == 1, "R5 err width", nerr, 1);
    check(ndone == 0, "R5 no done", ndone, 0);

    stall_mode = 1;
    launch(2'd2, 1'b1, 1'b1, 1'b1, 32'h0000_5000, 32'h0000_6000);
    repeat (2) @(negedge clk);
    #1;
    size_code = 2'd0; burst = 1'b0; src_addr = 32'h0000_7777; dst_addr = 32'h0000_8888;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    size_code = 2'd2; burst = 1'b1; src_addr = 32'h0000_5000; dst_addr = 32'h0000_6000;
    wait_end();
    verify(2'd2, 1'b1, 1'b1, 1'b1, 32'h0000_5000, 32'h0000_6000);
    repeat (10) @(negedge clk);
    #1;
    check(nr == 4 && nw == 4 && ndone == 1, "R8 start while busy ignored", nr + nw, 8);
    check(nerr == 0, "R8 no err while busy", nerr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule